// File: doc/BRIEF.md
# Message-Signalled Interrupt Ring Writer

This block receives message-signalled interrupts, each one carrying a 16-bit interrupt number. It stores each one as a 16-byte record in a circular buffer in system memory and drives a level interrupt to the host while unread records remain. Software sets up the buffer base address, the ring size, the consumer position and the operating mode through a small register file. It consumes records by comparing its read offset with the write offset after masking, and it returns records to the block by writing the read offset register.

Each record goes out on a simple memory write port as four 32-bit beats, each held until the memory side accepts it. The exposed write offset is a free-running byte counter and is not reduced to the ring size. The block uses only the low bits selected by the ring size to form the record address. When detection is enabled, a full ring either drops new messages or lets them overwrite old records, depending on the mode.

Top module: `msi_ring_writer`

## Requirements
- R1: Register word addresses are: 0 control, 3 buffer base bits 63:32, 4 buffer base bits 31:0, 5 read offset, 6 write offset. Any other address reads 0. The read and write offsets store bits 31:4 of the written value, and bits 3:0 read as 0.
- R2: Control bit 0 enables record writing, bit 1 enables full detection, bit 3 enables the interrupt output and bit 4 enables drop-on-full. Bits 9:8 = k give a ring of 2^(15+k) bytes. The position mask is (2^(15+k) − 1) with bits 3:0 cleared. Only these control bits are stored and read back.
- R3: An accepted message is written as four beats at addresses A, A+4, A+8 and A+12, where A = base + (write offset AND position mask). The first beat's data holds the interrupt number in bits 15:0 with bits 31:16 zero. The other three beats carry zero.
- R4: After the fourth beat is accepted, the write offset advances by 16. It is not reduced to the ring size, so it carries past the ring size.
- R5: The record address wraps: a write offset of one ring size maps to position 0.
- R6: A beat stays presented, with address and data unchanged, until mem_ready is high at a clock edge.
- R7: The ring is full when ((write offset + 16) AND mask) equals (read offset AND mask). When full, and detection and drop-on-full are both set, an arriving message is consumed without any memory write and the write offset is unchanged. A sticky flag then reads at control bit 16, and writing 1 to bit 16 clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: With full detection set but drop-on-full clear, a message arriving on a full ring is still written, and the sticky flag is set.
- R9: irq_out is high exactly when enable and interrupt enable are both set and (write offset AND mask) differs from (read offset AND mask). Writing the read offset updates it on the next cycle.
- R10: With enable clear, messages are accepted (msg_ready high) and discarded: no memory beat occurs and the write offset is unchanged.
- R11: msg_ready is low while a record is being written and high otherwise. A message is taken on a clock edge where msg_valid and msg_ready are both high.
- R12: After a synchronous active-low reset, all registers read 0 and msg_ready is high, while mem_valid and irq_out are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 3 | Register word address |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| msg_valid | input | 1 | Incoming interrupt message present |
| msg_num | input | 16 | Interrupt number of the message |
| msg_ready | output | 1 | Block can take a message |
| mem_addr | output | 64 | Byte address of the current beat |
| mem_data | output | 32 | Data of the current beat |
| mem_valid | output | 1 | Beat presented |
| mem_ready | input | 1 | Memory accepts the beat |
| irq_out | output | 1 | Level interrupt toward the host |

## Verification
The outputs that matter most show a wrong write offset, mask or latched record address as soon as it appears. The next beat address is off from that cycle, and irq_out changes level in the cycle after the faulty update. A wrong full decision shows when a message is accepted: either a beat appears on the following cycle where none was expected, or an expected beat is missing. Register readback then shows the sticky flag and the write offset. The bench runs a behavioural model that steps once per clock and compares beat valid, address, data, msg_ready and irq_out on every cycle. A fault is therefore caught within one cycle of reaching a port. Targeted reads cover the wrap, the carry, drop and overwrite on full, a second ring size and the disabled mode.

// File: rtl/msi_ring_pkg.sv
// Shared definitions for the interrupt ring writer: register word
// addresses, control bit positions, the control record and FSM states.
package msi_ring_pkg;

    localparam int CFG_AW = 3;
    localparam int SEL_W  = 2;

    localparam logic [CFG_AW-1:0] REG_CTRL    = 3'd0;
    localparam logic [CFG_AW-1:0] REG_BASE_HI = 3'd3;
    localparam logic [CFG_AW-1:0] REG_BASE_LO = 3'd4;
    localparam logic [CFG_AW-1:0] REG_RD_OFF  = 3'd5;
    localparam logic [CFG_AW-1:0] REG_WR_OFF  = 3'd6;

    localparam int CB_EN      = 0;
    localparam int CB_FULLDET = 1;
    localparam int CB_IRQ     = 3;
    localparam int CB_STOP    = 4;
    localparam int CB_SIZE    = 8;
    localparam int CB_STICKY  = 16;

    typedef struct packed {
        logic [SEL_W-1:0] size_sel;
        logic             stop_full;
        logic             irq_en;
        logic             full_det;
        logic             enable;
    } ring_ctrl_t;

    typedef enum logic {
        ST_IDLE,
        ST_BEAT
    } emit_st_e;

endpackage

// File: rtl/msi_ring_regs.sv
// Register file of the ring writer. Holds control, buffer base, read and
// write offsets and the sticky full flag. Assumes OW <= DW and that the
// base spans exactly two data words. An engine advance of the write
// offset takes priority over a software write in the same cycle.
module msi_ring_regs
    import msi_ring_pkg::*;
#(
    parameter int DW   = 32,
    parameter int OW   = 32,
    parameter int STEP = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              adv,
    input  logic              full_hit,
    output ring_ctrl_t        ctrl,
    output logic [2*DW-1:0]   base,
    output logic [OW-1:0]     rd_off,
    output logic [OW-1:0]     wr_off,
    output logic              sticky
);

    localparam int ALIGN = $clog2(STEP);

    ring_ctrl_t    ctrl_q;
    logic [DW-1:0] base_hi_q;
    logic [DW-1:0] base_lo_q;
    logic [OW-1:0] rd_off_q;
    logic [OW-1:0] wr_off_q;
    logic          sticky_q;
    logic [OW-1:0] wdata_aligned;
    logic          sticky_clr;

    assign wdata_aligned = {cfg_wdata[OW-1:ALIGN], {ALIGN{1'b0}}};
    assign sticky_clr    = cfg_wr && (cfg_addr == REG_CTRL) && cfg_wdata[CB_STICKY];

    // Control register: stores only the defined mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cfg_wr && cfg_addr == REG_CTRL) begin
            ctrl_q.enable    <= cfg_wdata[CB_EN];
            ctrl_q.full_det  <= cfg_wdata[CB_FULLDET];
            ctrl_q.irq_en    <= cfg_wdata[CB_IRQ];
            ctrl_q.stop_full <= cfg_wdata[CB_STOP];
            ctrl_q.size_sel  <= cfg_wdata[CB_SIZE +: SEL_W];
        end
    end

    // Buffer base address, written as two words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi_q <= '0;
            base_lo_q <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr == REG_BASE_HI) base_hi_q <= cfg_wdata;
            if (cfg_addr == REG_BASE_LO) base_lo_q <= cfg_wdata;
        end
    end

    // Consumer position, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_off_q <= '0;
        end else if (cfg_wr && cfg_addr == REG_RD_OFF) begin
            rd_off_q <= wdata_aligned;
        end
    end

    // Producer position: free-running, engine advance has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_off_q <= '0;
        end else if (adv) begin
            wr_off_q <= wr_off_q + OW'(STEP);
        end else if (cfg_wr && cfg_addr == REG_WR_OFF) begin
            wr_off_q <= wdata_aligned;
        end
    end

    // Sticky full flag: set wins over a write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= 1'b0;
        end else begin
            sticky_q <= full_hit | (sticky_q & ~sticky_clr);
        end
    end

    // Read mux over the register words.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_CTRL: begin
                cfg_rdata[CB_EN]              = ctrl_q.enable;
                cfg_rdata[CB_FULLDET]         = ctrl_q.full_det;
                cfg_rdata[CB_IRQ]             = ctrl_q.irq_en;
                cfg_rdata[CB_STOP]            = ctrl_q.stop_full;
                cfg_rdata[CB_SIZE +: SEL_W]   = ctrl_q.size_sel;
                cfg_rdata[CB_STICKY]          = sticky_q;
            end
            REG_BASE_HI: cfg_rdata = base_hi_q;
            REG_BASE_LO: cfg_rdata = base_lo_q;
            REG_RD_OFF:  cfg_rdata = DW'(rd_off_q);
            REG_WR_OFF:  cfg_rdata = DW'(wr_off_q);
            default:     cfg_rdata = '0;
        endcase
    end

    assign ctrl   = ctrl_q;
    assign base   = {base_hi_q, base_lo_q};
    assign rd_off = rd_off_q;
    assign wr_off = wr_off_q;
    assign sticky = sticky_q;

endmodule

// File: rtl/msi_ring_track.sv
// Ring position logic. Derives the position mask from the size selector,
// the record address, the full condition and the interrupt level. Purely
// combinational. Assumes MIN_SHIFT + 2^SEL_W - 1 < OW.
module msi_ring_track
    import msi_ring_pkg::*;
#(
    parameter int OW        = 32,
    parameter int AW        = 64,
    parameter int STEP      = 16,
    parameter int MIN_SHIFT = 15
) (
    input  logic [SEL_W-1:0] size_sel,
    input  logic [OW-1:0]    wr_off,
    input  logic [OW-1:0]    rd_off,
    input  logic [AW-1:0]    base,
    input  logic             enable,
    input  logic             irq_en,
    output logic [AW-1:0]    rec_addr,
    output logic             full,
    output logic             irq
);

    localparam int            NSIZES  = 1 << SEL_W;
    localparam logic [OW-1:0] LOW_CLR = ~OW'(STEP - 1);

    logic [OW-1:0] mask_tab [NSIZES];
    logic [OW-1:0] pos_mask;
    logic [OW-1:0] wr_pos;
    logic [OW-1:0] rd_pos;
    logic [OW-1:0] next_pos;

    // One position mask per size encoding.
    for (genvar g = 0; g < NSIZES; g++) begin : g_mask
        assign mask_tab[g] = ((OW'(1) << (MIN_SHIFT + g)) - OW'(1)) & LOW_CLR;
    end

    assign pos_mask = mask_tab[size_sel];
    assign wr_pos   = wr_off & pos_mask;
    assign rd_pos   = rd_off & pos_mask;
    assign next_pos = (wr_off + OW'(STEP)) & pos_mask;

    assign full     = (next_pos == rd_pos);
    assign irq      = enable && irq_en && (wr_pos != rd_pos);
    assign rec_addr = base + AW'(wr_pos);

endmodule

// File: rtl/msi_ring_emit.sv
// Record emitter. Takes one message at a time, decides drop or write,
// and sends the record as BEATS ascending data-width beats, each held
// until accepted. Assumes rec_addr is stable while idle.
module msi_ring_emit
    import msi_ring_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 64,
    parameter int NUM_W = 16,
    parameter int BEATS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    input  logic [NUM_W-1:0] msg_num,
    output logic             msg_ready,
    input  logic             enable,
    input  logic             full_det,
    input  logic             stop_full,
    input  logic             full,
    input  logic [AW-1:0]    rec_addr,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_data,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic             adv,
    output logic             full_hit
);

    localparam int BW      = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int BYTE_SH = $clog2(DW / 8);

    emit_st_e         state_q;
    logic [BW-1:0]    beat_q;
    logic [NUM_W-1:0] num_q;
    logic [AW-1:0]    addr_q;
    logic             accept;
    logic             drop;
    logic             start;
    logic             beat_done;
    logic             last_beat;

    assign msg_ready = (state_q == ST_IDLE);
    assign accept    = msg_valid && msg_ready;
    assign drop      = full && full_det && stop_full;
    assign start     = accept && enable && !drop;
    assign full_hit  = accept && enable && full && full_det;
    assign mem_valid = (state_q == ST_BEAT);
    assign beat_done = mem_valid && mem_ready;
    assign last_beat = (beat_q == BW'(BEATS - 1));
    assign adv       = beat_done && last_beat;

    // Sequencer: idle until a message starts a record, then step beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                state_q <= ST_BEAT;
                beat_q  <= '0;
            end
        end else if (beat_done) begin
            if (last_beat) begin
                state_q <= ST_IDLE;
            end else begin
                beat_q <= beat_q + BW'(1);
            end
        end
    end

    // Latch the interrupt number and record address at record start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q  <= '0;
            addr_q <= '0;
        end else if (start) begin
            num_q  <= msg_num;
            addr_q <= rec_addr;
        end
    end

    // Beat address and data from the latched record and beat index.
    always_comb begin
        mem_addr = addr_q + (AW'(beat_q) << BYTE_SH);
        mem_data = (beat_q == '0) ? DW'(num_q) : '0;
    end

endmodule

// File: rtl/msi_ring_writer.sv
// Top of the interrupt ring writer: register file, ring position logic
// and record emitter. Assumes REC_BYTES is a power of two multiple of the
// data width in bytes and that the base address spans two data words.
module msi_ring_writer
    import msi_ring_pkg::*;
#(
    parameter int DW        = 32,
    parameter int NUM_W     = 16,
    parameter int REC_BYTES = 16,
    parameter int MIN_SHIFT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              msg_valid,
    input  logic [NUM_W-1:0]  msg_num,
    output logic              msg_ready,
    output logic [2*DW-1:0]   mem_addr,
    output logic [DW-1:0]     mem_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              irq_out
);

    localparam int AW    = 2 * DW;
    localparam int OW    = DW;
    localparam int BEATS = REC_BYTES / (DW / 8);

    ring_ctrl_t    ctrl;
    logic [AW-1:0] base;
    logic [OW-1:0] rd_off;
    logic [OW-1:0] wr_off;
    logic          sticky;
    logic [AW-1:0] rec_addr;
    logic          ring_full;
    logic          adv;
    logic          full_hit;
    logic          ctl_en;
    logic          ctl_fd;
    logic          ctl_stop;

    assign ctl_en   = ctrl.enable;
    assign ctl_fd   = ctrl.full_det;
    assign ctl_stop = ctrl.stop_full;

    msi_ring_regs #(
        .DW   (DW),
        .OW   (OW),
        .STEP (REC_BYTES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_addr  (cfg_addr),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .adv       (adv),
        .full_hit  (full_hit),
        .ctrl      (ctrl),
        .base      (base),
        .rd_off    (rd_off),
        .wr_off    (wr_off),
        .sticky    (sticky)
    );

    msi_ring_track #(
        .OW        (OW),
        .AW        (AW),
        .STEP      (REC_BYTES),
        .MIN_SHIFT (MIN_SHIFT)
    ) u_track (
        .size_sel (ctrl.size_sel),
        .wr_off   (wr_off),
        .rd_off   (rd_off),
        .base     (base),
        .enable   (ctl_en),
        .irq_en   (ctrl.irq_en),
        .rec_addr (rec_addr),
        .full     (ring_full),
        .irq      (irq_out)
    );

    msi_ring_emit #(
        .DW    (DW),
        .AW    (AW),
        .NUM_W (NUM_W),
        .BEATS (BEATS)
    ) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_valid (msg_valid),
        .msg_num   (msg_num),
        .msg_ready (msg_ready),
        .enable    (ctl_en),
        .full_det  (ctl_fd),
        .stop_full (ctl_stop),
        .full      (ring_full),
        .rec_addr  (rec_addr),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .adv       (adv),
        .full_hit  (full_hit)
    );

endmodule

// File: rtl/msi_ring_chk.sv
// Property checker for the ring writer, bound into the top module.
// Relates the port handshakes to the offset and mode state over time.
module msi_ring_chk
    import msi_ring_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 64,
    parameter int OW   = 32,
    parameter int STEP = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic              cfg_wr,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [AW-1:0]     mem_addr,
    input logic [DW-1:0]     mem_data,
    input logic [OW-1:0]     wr_off,
    input logic              ring_full,
    input logic              ctl_en,
    input logic              ctl_fd,
    input logic              ctl_stop,
    input logic              sticky
);

    localparam logic [AW-1:0] STRIDE = AW'(DW / 8);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R6

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !msg_ready); // R11

    AST_BEAT_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_valid && mem_ready) && mem_valid |-> mem_addr == $past(mem_addr) + STRIDE); // R3

    AST_WOFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_off != $past(wr_off)) && !$past(cfg_wr && cfg_addr == REG_WR_OFF)
            |-> wr_off == $past(wr_off) + OW'(STEP)); // R4

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready && ctl_en && ctl_fd && ctl_stop && ring_full
            |=> !mem_valid && sticky); // R7

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready && !ctl_en |=> !mem_valid); // R10

endmodule

bind msi_ring_writer msi_ring_chk #(
    .DW   (DW),
    .AW   (AW),
    .OW   (OW),
    .STEP (REC_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_addr  (cfg_addr),
    .cfg_wr    (cfg_wr),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .wr_off    (wr_off),
    .ring_full (ring_full),
    .ctl_en    (ctl_en),
    .ctl_fd    (ctl_fd),
    .ctl_stop  (ctl_stop),
    .sticky    (sticky)
);

// File: tb/msi_ring_writer_test.sv
`timescale 1ns/1ps
// Bench for the ring writer: behavioural model stepped every clock and
// compared on every falling edge, plus targeted register reads.
module msi_ring_writer_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cfg_addr;
    logic        cfg_wr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        msg_valid;
    logic [15:0] msg_num;
    logic        msg_ready;
    logic [63:0] mem_addr;
    logic [31:0] mem_data;
    logic        mem_valid;
    logic        mem_ready;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit stall_mode = 1'b0;
    int cyc = 0;

    // model state
    logic [31:0] m_ctrl, m_roff, m_woff;
    logic [63:0] m_base, m_rec;
    logic        m_sticky, m_busy;
    int          m_beat;
    logic [15:0] m_num;
    logic [63:0] cap_addr;
    int          hs_cnt;

    localparam logic [63:0] BASE = 64'h0000_0001_2000_0000;

    always #2.5 clk = ~clk;

    msi_ring_writer uut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msg_valid(msg_valid),
        .msg_num(msg_num), .msg_ready(msg_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .irq_out(irq_out)
    );

    function automatic logic [31:0] mask_of(logic [1:0] k);
        return ((32'd1 << (15 + k)) - 32'd1) & ~32'hF;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural model, stepped on each rising edge
    always @(posedge clk) begin
        logic [31:0] mk;
        logic        acc, nfull, set_st, start;
        logic [63:0] rec_pre;
        if (!rst_n) begin
            m_ctrl = 0; m_roff = 0; m_woff = 0; m_base = 0; m_rec = 0;
            m_sticky = 0; m_busy = 0; m_beat = 0; m_num = 0; hs_cnt = 0;
        end else begin
            mk      = mask_of(m_ctrl[9:8]);
            acc     = !m_busy && msg_valid;
            nfull   = (((m_woff + 32'd16) & mk) == (m_roff & mk));
            set_st  = acc && m_ctrl[0] && m_ctrl[1] && nfull;
            start   = acc && m_ctrl[0] && !(m_ctrl[1] && m_ctrl[4] && nfull);
            rec_pre = m_base + {32'h0, m_woff & mk};
            if (mem_valid && mem_ready) begin
                hs_cnt++;
                if (m_beat == 0) cap_addr = mem_addr;
            end
            if (cfg_wr) begin
                case (cfg_addr)
                    3'd0: begin
                        m_ctrl = cfg_wdata & 32'h31B;
                        if (cfg_wdata[16]) m_sticky = 0;
                    end
                    3'd3: m_base[63:32] = cfg_wdata;
                    3'd4: m_base[31:0]  = cfg_wdata;
                    3'd5: m_roff = cfg_wdata & ~32'hF;
                    3'd6: m_woff = cfg_wdata & ~32'hF;
                    default: ;
                endcase
            end
            if (set_st) m_sticky = 1;
            if (m_busy) begin
                if (mem_ready) begin
                    if (m_beat == 3) begin
                        m_busy = 0;
                        m_woff = m_woff + 32'd16;
                    end else begin
                        m_beat++;
                    end
                end
            end else if (start) begin
                m_busy = 1; m_beat = 0; m_num = msg_num; m_rec = rec_pre;
            end
        end
    end

    // per-cycle comparison of the outputs against the model
    always @(negedge clk) begin
        logic [31:0] mk;
        if (rst_n) begin
            mk = mask_of(m_ctrl[9:8]);
            check("R11 msg_ready", {63'h0, msg_ready}, {63'h0, !m_busy});
            check("R3 mem_valid", {63'h0, mem_valid}, {63'h0, m_busy});
            if (m_busy) begin
                check("R5 mem_addr", mem_addr, m_rec + 64'(4 * m_beat));
                check("R3 mem_data", {32'h0, mem_data},
                      {32'h0, (m_beat == 0) ? {16'h0, m_num} : 32'h0});
            end
            check("R9 irq_out", {63'h0, irq_out},
                  {63'h0, m_ctrl[0] && m_ctrl[3] && ((m_woff & mk) != (m_roff & mk))});
        end
    end

    // memory ready pattern
    always @(negedge clk) begin
        cyc++;
        mem_ready <= stall_mode ? (cyc % 3 == 0) : 1'b1;
    end

    task automatic cfg_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_check(logic [2:0] a, logic [31:0] e, string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, {32'h0, cfg_rdata}, {32'h0, e});
    endtask

    task automatic send(logic [15:0] n);
        @(negedge clk);
        while (!msg_ready) @(negedge clk);
        msg_valid = 1'b1; msg_num = n;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (!msg_ready) @(negedge clk);
    endtask

    initial begin
        int hs_before;
        rst_n = 1'b0; cfg_addr = 0; cfg_wr = 0; cfg_wdata = 0;
        msg_valid = 0; msg_num = 0; mem_ready = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R12 reset state
        rd_check(3'd0, 32'h0, "R12 ctrl after reset");
        rd_check(3'd3, 32'h0, "R12 base hi after reset");
        rd_check(3'd4, 32'h0, "R12 base lo after reset");
        rd_check(3'd5, 32'h0, "R12 read offset after reset");
        rd_check(3'd6, 32'h0, "R12 write offset after reset");
        check("R12 mem_valid after reset", {63'h0, mem_valid}, 64'h0);
        check("R12 irq_out after reset", {63'h0, irq_out}, 64'h0);

        // R1 R2 register decode and stored bits
        cfg_write(3'd0, 32'hFFFF_FFFF);
        rd_check(3'd0, 32'h0000_031B, "R2 ctrl stored bits");
        cfg_write(3'd3, BASE[63:32]);
        cfg_write(3'd4, BASE[31:0]);
        rd_check(3'd3, BASE[63:32], "R1 base hi");
        rd_check(3'd4, BASE[31:0], "R1 base lo");
        rd_check(3'd7, 32'h0, "R1 unused address");
        cfg_write(3'd5, 32'h1234_5678);
        rd_check(3'd5, 32'h1234_5670, "R1 read offset alignment");
        cfg_write(3'd5, 32'h0);
        cfg_write(3'd0, 32'h0000_001B);

        // R3 R4 main path, no stalls
        send(16'hA5A5); send(16'h0001); send(16'hFFFF);
        wait_idle();
        rd_check(3'd6, 32'h30, "R4 write offset after three records");
        check("R9 irq high with unread records", {63'h0, irq_out}, 64'h1);
        cfg_write(3'd5, 32'h30);
        check("R9 irq low after read offset update", {63'h0, irq_out}, 64'h0);

        // R6 stalled memory
        stall_mode = 1'b1;
        send(16'h1234);
        wait_idle();
        stall_mode = 1'b0;
        rd_check(3'd6, 32'h40, "R6 write offset after stalled record");
        check("R3 record address under stall", cap_addr, BASE + 64'h30);

        // R5 wraparound and R4 carry
        cfg_write(3'd6, 32'h7FF0);
        cfg_write(3'd5, 32'h7FF0);
        send(16'h0055);
        wait_idle();
        check("R5 last slot address", cap_addr, BASE + 64'h7FF0);
        rd_check(3'd6, 32'h8000, "R4 write offset carries past ring size");
        send(16'h0066);
        wait_idle();
        check("R5 wrapped address", cap_addr, BASE);
        rd_check(3'd6, 32'h8010, "R4 offset after wrap");

        // R7 drop on full
        cfg_write(3'd5, 32'h0);
        cfg_write(3'd6, 32'h7FE0);
        send(16'h0077);
        wait_idle();
        rd_check(3'd6, 32'h7FF0, "R7 record before full");
        hs_before = hs_cnt;
        send(16'h0088);
        repeat (6) @(negedge clk);
        check("R7 no beats when dropped", 64'(hs_cnt), 64'(hs_before));
        rd_check(3'd6, 32'h7FF0, "R7 offset unchanged on drop");
        rd_check(3'd0, 32'h0001_001B, "R7 sticky set");
        cfg_write(3'd0, 32'h0001_001B);
        rd_check(3'd0, 32'h0000_001B, "R7 sticky cleared");

        // R8 overwrite when drop-on-full is off
        cfg_write(3'd0, 32'h0000_000B);
        send(16'h0099);
        wait_idle();
        rd_check(3'd6, 32'h8000, "R8 record written on full");
        rd_check(3'd0, 32'h0001_000B, "R8 sticky set on overwrite");

        // R2 larger ring size
        cfg_write(3'd0, 32'h0001_010B);
        cfg_write(3'd6, 32'h8000);
        send(16'h00AB);
        wait_idle();
        check("R2 64KB ring address", cap_addr, BASE + 64'h8000);
        rd_check(3'd6, 32'h8010, "R2 offset in 64KB ring");

        // R10 disabled block, R9 gated by enable
        cfg_write(3'd0, 32'h0000_0008);
        hs_before = hs_cnt;
        send(16'h00CD);
        repeat (6) @(negedge clk);
        check("R10 no beats while disabled", 64'(hs_cnt), 64'(hs_before));
        rd_check(3'd6, 32'h8010, "R10 offset unchanged while disabled");
        check("R9 irq low while disabled", {63'h0, irq_out}, 64'h0);
        cfg_write(3'd0, 32'h0000_0109);
        check("R9 irq high when re-enabled", {63'h0, irq_out}, 64'h1);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule